// File: doc/BRIEF.md
# Spatial Region Footprint Prefetcher

This block watches every access that reaches the first-level data cache and learns which cache lines of a fixed-size memory region a program touches together. The first access to a region that is not being tracked is its trigger. It opens a live record that holds the region address, the program counter of the trigger and the line offset of the trigger inside the region. Each later access to that region marks its line in a footprint bit vector. When the cache reports that a line of the region has left the cache, or when the record is pushed out to make room, the footprint is saved. It is stored under a key made of the trigger program counter and the trigger line offset.

When a later trigger access carries a key that is in the store, the block replays the saved footprint against the new region. It issues one prefetch address per cycle for each marked line, leaving out the line the trigger itself touched. The prefetch output uses a valid/ready handshake, so the cache side can hold the stream back. The block holds no cache data: it only observes accesses and eviction notices and emits line addresses.

Top module: `sp_region_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and no region is tracked, so no access can replay a footprint until one has been stored.
- R2: A line is 64 bytes and a region is 2048 bytes: address bits [10:6] select the line within the region and bits [31:11] name the region. An access to a region that is not tracked opens a record holding the region, the access PC and the line offset, with only the trigger line marked.
- R3: Every access to a tracked region marks its line in that region's footprint, whether or not the line was already marked.
- R4: An eviction notice whose address falls in a tracked region ends that record and stores its footprint under the key (trigger PC, trigger offset). An eviction notice for an untracked region changes nothing.
- R5: At most 16 regions are tracked. A trigger that arrives while all 16 are in use displaces the region accessed least recently and stores that region's footprint.
- R6: The footprint store has 256 entries, direct mapped, indexed by PC[9:2] XOR the zero-extended 5-bit trigger offset. An entry keeps the full key: a key with a different PC or offset that maps to the same index replaces it, and a lookup with the older key then misses.
- R7: A trigger access whose full key matches a stored entry starts a stream that prefetches every marked line of the new region except the trigger line, at address {region, line, 6'b0}.
- R8: Stream addresses come out in ascending line order, at most one per cycle. While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` does not change.
- R9: A matching trigger that arrives while a stream still has lines to issue, including the cycle of its last handshake, is dropped. A lookup sees the store as it was before any update made in the same cycle.
- R10: When an eviction notice and an access arrive in the same cycle, the eviction is handled and the access is ignored: it neither marks a line nor opens a record.
- R11: An access to a region that is already tracked never starts a stream, even if its PC and offset form a stored key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A data-cache access is presented this cycle |
| acc_pc | input | 32 | Program counter of the access |
| acc_addr | input | 32 | Byte address of the access |
| evict_valid | input | 1 | A line was evicted or invalidated this cycle |
| evict_addr | input | 32 | Byte address within the line that left the cache |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | 32 | Line-aligned prefetch address |
| pf_ready | input | 1 | The consumer takes the offered address this cycle |

## Verification
The bench builds the block with its default parameters: 64-byte lines, 2 KiB regions, 16 tracked regions and a 256-entry store hashed on PC bits [9:2]. With these values, sixteen openings fill the tracker, so the seventeenth forces a least-recently-used displacement. Two keys with PC values four bytes apart and offsets 0 and 1 fall on the same store index, which exercises replacement within the direct-mapped store. A small pool of six regions and four PCs in the random phase keeps stored keys hitting often, so streams overlap new triggers and back-pressure under a reference model that tracks recency by timestamps.

// File: rtl/sp_pkg.sv
package sp_pkg;

   // Action the region tracker takes in one cycle
   typedef enum logic [1:0] {
      AT_IDLE  = 2'd0,
      AT_TOUCH = 2'd1,
      AT_OPEN  = 2'd2,
      AT_DROP  = 2'd3
   } at_act_e;

endpackage

// File: rtl/sp_active_table.sv
module sp_active_table
   import sp_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 21,
   parameter int OFF_W   = 5,
   parameter int PC_W    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [TAG_W-1:0]      acc_tag,
   input  logic [OFF_W-1:0]      acc_off,
   input  logic [PC_W-1:0]       acc_pc,
   input  logic                  evict_valid,
   input  logic [TAG_W-1:0]      evict_tag,
   output at_act_e               act,
   output logic                  close_valid,
   output logic [PC_W-1:0]       close_pc,
   output logic [OFF_W-1:0]      close_off,
   output logic [(1<<OFF_W)-1:0] close_vec
);
   localparam int LINES = 1 << OFF_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] vld_q, hit_v, ehit_v;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [PC_W-1:0]    pc_q   [ENTRIES];
   logic [OFF_W-1:0]   toff_q [ENTRIES];
   logic [LINES-1:0]   vec_q  [ENTRIES];
   logic [IDX_W-1:0]   age_q  [ENTRIES];

   logic [IDX_W-1:0] hit_idx, ev_idx, free_idx, lru_idx, sel;
   logic             any_free;
   logic [LINES-1:0] acc_bit;

   assign acc_bit = LINES'(1) << acc_off;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_v[g]  = vld_q[g] && (tag_q[g] == acc_tag);
      assign ehit_v[g] = vld_q[g] && (tag_q[g] == evict_tag);
   end

   always_comb begin
      hit_idx  = '0;
      ev_idx   = '0;
      free_idx = '0;
      lru_idx  = '0;
      any_free = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_v[i])  hit_idx = IDX_W'(i);
         if (ehit_v[i]) ev_idx  = IDX_W'(i);
         if (!vld_q[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
         if (age_q[i] == IDX_W'(ENTRIES - 1)) lru_idx = IDX_W'(i);
      end
   end

   always_comb begin
      act = AT_IDLE;
      sel = '0;
      if (evict_valid) begin
         if (|ehit_v) begin
            act = AT_DROP;
            sel = ev_idx;
         end
      end else if (acc_valid) begin
         if (|hit_v) begin
            act = AT_TOUCH;
            sel = hit_idx;
         end else begin
            act = AT_OPEN;
            sel = any_free ? free_idx : lru_idx;
         end
      end
   end

   assign close_valid = (act == AT_DROP) || ((act == AT_OPEN) && !any_free);
   assign close_pc    = pc_q[sel];
   assign close_off   = toff_q[sel];
   assign close_vec   = vec_q[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int j = 0; j < ENTRIES; j++) age_q[j] <= IDX_W'(j);
      end else begin
         case (act)
            AT_DROP:  vld_q[sel] <= 1'b0;
            AT_TOUCH: vec_q[sel] <= vec_q[sel] | acc_bit;
            AT_OPEN: begin
               vld_q[sel]  <= 1'b1;
               tag_q[sel]  <= acc_tag;
               pc_q[sel]   <= acc_pc;
               toff_q[sel] <= acc_off;
               vec_q[sel]  <= acc_bit;
            end
            default: ;
         endcase
         if ((act == AT_TOUCH) || (act == AT_OPEN)) begin
            for (int j = 0; j < ENTRIES; j++) begin
               if (IDX_W'(j) == sel) age_q[j] <= '0;
               else if (age_q[j] < age_q[sel]) age_q[j] <= age_q[j] + 1'b1;
            end
         end
      end
   end

   // R2: a region is never tracked by two records
   p_single_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));

   // R4: occupancy only falls on an eviction notice
   p_occupancy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !evict_valid |=> ($countones(vld_q) >= $past($countones(vld_q))));

endmodule

// File: rtl/sp_pattern_table.sv
module sp_pattern_table #(
   parameter int ENTRIES  = 256,
   parameter int PC_W     = 32,
   parameter int PC_LSB   = 2,
   parameter int OFF_W    = 5,
   parameter bit HASH_OFF = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PC_W-1:0]       wr_pc,
   input  logic [OFF_W-1:0]      wr_off,
   input  logic [(1<<OFF_W)-1:0] wr_vec,
   input  logic [PC_W-1:0]       rd_pc,
   input  logic [OFF_W-1:0]      rd_off,
   output logic                  rd_hit,
   output logic [(1<<OFF_W)-1:0] rd_vec
);
   localparam int LINES = 1 << OFF_W;
   localparam int IDX_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] vld_q;
   logic [PC_W-1:0]    pc_q  [ENTRIES];
   logic [OFF_W-1:0]   off_q [ENTRIES];
   logic [LINES-1:0]   vec_q [ENTRIES];
   logic [IDX_W-1:0]   rd_idx, wr_idx;

   if (HASH_OFF) begin : g_xor_hash
      assign rd_idx = rd_pc[PC_LSB +: IDX_W] ^ IDX_W'(rd_off);
      assign wr_idx = wr_pc[PC_LSB +: IDX_W] ^ IDX_W'(wr_off);
   end else begin : g_pc_hash
      assign rd_idx = rd_pc[PC_LSB +: IDX_W];
      assign wr_idx = wr_pc[PC_LSB +: IDX_W];
   end

   assign rd_hit = vld_q[rd_idx] && (pc_q[rd_idx] == rd_pc) && (off_q[rd_idx] == rd_off);
   assign rd_vec = vec_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
         pc_q[wr_idx]  <= wr_pc;
         off_q[wr_idx] <= wr_off;
         vec_q[wr_idx] <= wr_vec;
      end
   end

   // R6: a stored footprint lands whole at its hashed slot
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_idx)] && (vec_q[$past(wr_idx)] == $past(wr_vec))
                 && (pc_q[$past(wr_idx)] == $past(wr_pc))));

endmodule

// File: rtl/sp_stream_issue.sv
module sp_stream_issue #(
   parameter int TAG_W     = 21,
   parameter int OFF_W     = 5,
   parameter int LINE_BITS = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_valid,
   input  logic [TAG_W-1:0]             load_tag,
   input  logic [(1<<OFF_W)-1:0]        load_mask,
   output logic                         pf_valid,
   output logic [TAG_W+OFF_W+LINE_BITS-1:0] pf_addr,
   input  logic                         pf_ready
);
   localparam int LINES = 1 << OFF_W;

   logic [LINES-1:0] mask_q;
   logic [TAG_W-1:0] tag_q;
   logic [OFF_W-1:0] low_off;
   logic             busy;

   assign busy = |mask_q;

   always_comb begin
      low_off = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (mask_q[i]) low_off = OFF_W'(i);
      end
   end

   assign pf_valid = busy;
   assign pf_addr  = {tag_q, low_off, {LINE_BITS{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         tag_q  <= '0;
      end else if (!busy && load_valid) begin
         mask_q <= load_mask;
         tag_q  <= load_tag;
      end else if (busy && pf_ready) begin
         mask_q <= mask_q & (mask_q - 1'b1);
      end
   end

   // R8: an offered address is held until taken
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

   // R8: within one stream the lines rise
   p_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && pf_ready && ($countones(mask_q) > 1)) |=> (pf_valid && (pf_addr > $past(pf_addr))));

   // R9: a prediction offered to a busy, stalled stream leaves it untouched
   p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load_valid && !pf_ready) |=> ($stable(mask_q) && $stable(tag_q)));

endmodule

// File: rtl/sp_region_prefetcher.sv
module sp_region_prefetcher
   import sp_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int PC_W         = 32,
   parameter int LINE_BYTES   = 64,
   parameter int REGION_BYTES = 2048,
   parameter int AT_ENTRIES   = 16,
   parameter int PT_ENTRIES   = 256,
   parameter int PC_LSB       = 2,
   parameter bit PT_HASH_OFF  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [PC_W-1:0]   acc_pc,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_ready
);
   localparam int LINE_BITS = $clog2(LINE_BYTES);
   localparam int OFF_W     = $clog2(REGION_BYTES) - LINE_BITS;
   localparam int LINES     = 1 << OFF_W;
   localparam int TAG_W     = ADDR_W - LINE_BITS - OFF_W;
   localparam int PT_IDX_W  = $clog2(PT_ENTRIES);

   if ((1 << LINE_BITS) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((1 << $clog2(REGION_BYTES)) != REGION_BYTES || OFF_W < 1) begin : g_bad_region
      $error("REGION_BYTES must be a power of two larger than a line");
   end
   if ((1 << $clog2(AT_ENTRIES)) != AT_ENTRIES || AT_ENTRIES < 2) begin : g_bad_at
      $error("AT_ENTRIES must be a power of two of at least 2");
   end
   if ((1 << PT_IDX_W) != PT_ENTRIES || PT_IDX_W < OFF_W) begin : g_bad_pt
      $error("PT_ENTRIES must be a power of two covering the offset field");
   end
   if (PC_LSB + PT_IDX_W > PC_W) begin : g_bad_pc
      $error("PC too narrow for the store index");
   end

   logic [TAG_W-1:0] acc_tag, evict_tag;
   logic [OFF_W-1:0] acc_off;
   at_act_e          act;
   logic             close_valid;
   logic [PC_W-1:0]  close_pc;
   logic [OFF_W-1:0] close_off;
   logic [LINES-1:0] close_vec;
   logic             rd_hit;
   logic [LINES-1:0] rd_vec, pred_mask;
   logic             load_valid;
   logic             unused_low;

   assign acc_tag    = acc_addr[ADDR_W-1 -: TAG_W];
   assign acc_off    = acc_addr[LINE_BITS +: OFF_W];
   assign evict_tag  = evict_addr[ADDR_W-1 -: TAG_W];
   assign unused_low = ^{acc_addr[LINE_BITS-1:0], evict_addr[LINE_BITS+OFF_W-1:0]};

   sp_active_table #(
      .ENTRIES (AT_ENTRIES),
      .TAG_W   (TAG_W),
      .OFF_W   (OFF_W),
      .PC_W    (PC_W)
   ) i_active (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .acc_tag     (acc_tag),
      .acc_off     (acc_off),
      .acc_pc      (acc_pc),
      .evict_valid (evict_valid),
      .evict_tag   (evict_tag),
      .act         (act),
      .close_valid (close_valid),
      .close_pc    (close_pc),
      .close_off   (close_off),
      .close_vec   (close_vec)
   );

   sp_pattern_table #(
      .ENTRIES  (PT_ENTRIES),
      .PC_W     (PC_W),
      .PC_LSB   (PC_LSB),
      .OFF_W    (OFF_W),
      .HASH_OFF (PT_HASH_OFF)
   ) i_pattern (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (close_valid),
      .wr_pc  (close_pc),
      .wr_off (close_off),
      .wr_vec (close_vec),
      .rd_pc  (acc_pc),
      .rd_off (acc_off),
      .rd_hit (rd_hit),
      .rd_vec (rd_vec)
   );

   assign pred_mask  = rd_vec & ~(LINES'(1) << acc_off);
   assign load_valid = (act == AT_OPEN) && rd_hit && (pred_mask != '0);

   sp_stream_issue #(
      .TAG_W     (TAG_W),
      .OFF_W     (OFF_W),
      .LINE_BITS (LINE_BITS)
   ) i_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_valid (load_valid),
      .load_tag   (acc_tag),
      .load_mask  (pred_mask),
      .pf_valid   (pf_valid),
      .pf_addr    (pf_addr),
      .pf_ready   (pf_ready)
   );

   // R11: an access to a tracked region never feeds the streamer
   p_touch_no_stream_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (act == AT_TOUCH && !pf_valid) |=> !pf_valid);

endmodule

// File: tb/test_sp_region_prefetcher.sv
module test_sp_region_prefetcher;
   localparam int CLK_P = 10;
   localparam int WATCHDOG = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_pc = '0;
   logic [31:0] acc_addr = '0;
   logic        evict_valid = 1'b0;
   logic [31:0] evict_addr = '0;
   logic        pf_valid;
   logic [31:0] pf_addr;
   logic        pf_ready = 1'b1;

   sp_region_prefetcher i_sp_region_prefetcher (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
   );

   always #(CLK_P/2) clk = ~clk;

   int    checks = 0;
   int    failures = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string phase = "R1 reset";

   // ---------------- behavioural reference ----------------
   typedef struct {
      bit [20:0] tag;
      bit [31:0] pc;
      int        off;
      bit [31:0] vec;
      longint    used;
   } ent_t;

   ent_t      trk[$];
   bit [31:0] st_pc  [int];
   int        st_off [int];
   bit [31:0] st_vec [int];
   bit [31:0] sq[$];
   bit [31:0] issued[$];
   longint    tnow = 0;

   function automatic int pidx(bit [31:0] pc, int off);
      return ((pc >> 2) & 255) ^ off;
   endfunction

   task automatic store(ent_t e);
      int ix = pidx(e.pc, e.off);
      st_pc[ix]  = e.pc;
      st_off[ix] = e.off;
      st_vec[ix] = e.vec;
   endtask

   function automatic int find(bit [20:0] tg);
      foreach (trk[i]) if (trk[i].tag == tg) return i;
      return -1;
   endfunction

   task automatic model_step();
      bit idle = (sq.size() == 0);
      tnow++;
      if (!idle && pf_ready) void'(sq.pop_front());
      if (evict_valid) begin
         int f = find(evict_addr[31:11]);
         if (f >= 0) begin
            store(trk[f]);
            trk.delete(f);
         end
      end else if (acc_valid) begin
         bit [20:0] tg = acc_addr[31:11];
         int off = int'(acc_addr[10:6]);
         int f = find(tg);
         if (f >= 0) begin
            trk[f].vec |= (32'd1 << off);
            trk[f].used = tnow;
         end else begin
            int ix = pidx(acc_pc, off);
            ent_t n;
            if (idle && st_vec.exists(ix) && st_pc[ix] == acc_pc && st_off[ix] == off) begin
               for (int l = 0; l < 32; l++)
                  if (st_vec[ix][l] && l != off) sq.push_back({tg, 5'(l), 6'b0});
            end
            if (trk.size() == 16) begin
               int v = 0;
               foreach (trk[i]) if (trk[i].used < trk[v].used) v = i;
               store(trk[v]);
               trk.delete(v);
            end
            n.tag = tg; n.pc = acc_pc; n.off = off; n.vec = 32'd1 << off; n.used = tnow;
            trk.push_back(n);
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         trk.delete(); st_pc.delete(); st_off.delete(); st_vec.delete(); sq.delete();
      end else begin
         model_step();
      end
   end

   // ---------------- checking ----------------
   task automatic chk(bit ok, string req, string what, bit [31:0] act_v, bit [31:0] exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act_v, exp_v);
      end
   endtask

   always begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && !done) begin
         chk(pf_valid == (sq.size() != 0), phase, "pf_valid", 32'(pf_valid), 32'(sq.size() != 0));
         if (pf_valid && sq.size() != 0) chk(pf_addr == sq[0], phase, "pf_addr", pf_addr, sq[0]);
         if (pf_valid && pf_ready) issued.push_back(pf_addr);
      end
   end

   task automatic expect_list(string req, bit [31:0] exp[$]);
      chk(issued.size() == exp.size(), req, "issued count", 32'(issued.size()), 32'(exp.size()));
      foreach (exp[i]) begin
         if (i < issued.size()) chk(issued[i] == exp[i], req, "issued addr", issued[i], exp[i]);
      end
      issued.delete();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected=%0d", cycles, WATCHDOG);
         summary();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(bit av, bit [31:0] pc, bit [31:0] a, bit ev, bit [31:0] ea);
      @(negedge clk);
      acc_valid = av; acc_pc = pc; acc_addr = a;
      evict_valid = ev; evict_addr = ea;
   endtask

   task automatic acc(bit [31:0] pc, bit [31:0] base, int off);
      drive(1'b1, pc, base + 32'(off * 64), 1'b0, '0);
   endtask

   task automatic evict(bit [31:0] base, int off);
      drive(1'b0, '0, '0, 1'b1, base + 32'(off * 64));
   endtask

   task automatic idle(int n);
      repeat (n) drive(1'b0, '0, '0, 1'b0, '0);
   endtask

   initial begin
      bit [31:0] e[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      chk(pf_valid == 1'b0, "R1", "pf_valid after reset", 32'(pf_valid), 32'd0);

      // R2 R3 R4 R7: learn a footprint, end it by eviction, replay it
      phase = "R2 R3 R4 R7 learn and replay";
      acc(32'h1000, 32'h0001_0000, 3);
      acc(32'h1000, 32'h0001_0000, 5);
      acc(32'h2000, 32'h0001_0000, 9);
      acc(32'h1000, 32'h0001_0000, 20);
      acc(32'h1000, 32'h0001_0000, 3);
      evict(32'h0009_0000, 0);
      evict(32'h0001_0000, 9);
      idle(2);
      chk(pf_valid == 1'b0, "R4", "no stream from eviction", 32'(pf_valid), 32'd0);
      acc(32'h1000, 32'h0002_0000, 3);
      idle(6);
      e = '{32'h0002_0140, 32'h0002_0240, 32'h0002_0500};
      expect_list("R7", e);

      // R8: back-pressure holds the stream
      phase = "R8 back-pressure";
      pf_ready = 1'b0;
      acc(32'h1000, 32'h0002_8000, 3);
      idle(4);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         pf_ready = i[0];
      end
      pf_ready = 1'b1;
      idle(4);
      e = '{32'h0002_8140, 32'h0002_8240, 32'h0002_8500};
      expect_list("R8", e);

      // R9: second trigger while stream pending is dropped
      phase = "R9 busy drop";
      pf_ready = 1'b0;
      acc(32'h1000, 32'h0003_0000, 3);
      acc(32'h1000, 32'h0003_8000, 3);
      @(negedge clk);
      pf_ready = 1'b1;
      idle(6);
      e = '{32'h0003_0140, 32'h0003_0240, 32'h0003_0500};
      expect_list("R9", e);

      // R5: seventeenth opening displaces least recently used
      phase = "R5 displacement";
      acc(32'h5000, 32'h0100_0000, 2);
      acc(32'h5000, 32'h0100_0000, 7);
      for (int k = 1; k <= 16; k++) acc(32'h6000 + 32'(k * 16), 32'h0100_0000 + 32'(k * 32'h800), 0);
      idle(2);
      acc(32'h5000, 32'h0110_0000, 2);
      idle(4);
      e = '{32'h0110_01C0};
      expect_list("R5", e);

      // R6: two keys on one index, the later one replaces
      phase = "R6 index alias";
      acc(32'h7004, 32'h0120_0000, 0);
      acc(32'h7004, 32'h0120_0000, 4);
      evict(32'h0120_0000, 4);
      acc(32'h7000, 32'h0120_0800, 1);
      acc(32'h7000, 32'h0120_0800, 6);
      evict(32'h0120_0800, 1);
      idle(2);
      acc(32'h7004, 32'h0120_1000, 0);
      idle(3);
      e = '{};
      expect_list("R6", e);
      acc(32'h7000, 32'h0120_1800, 1);
      idle(4);
      e = '{32'h0120_1980};
      expect_list("R6", e);

      // R11: access to tracked region with a stored key
      phase = "R11 tracked access";
      acc(32'h7000, 32'h0120_1800, 1);
      acc(32'h7000, 32'h0120_1800, 6);
      idle(3);
      e = '{};
      expect_list("R11", e);

      // R10: eviction and access in one cycle
      phase = "R10 same-cycle eviction";
      acc(32'h7100, 32'h0130_0000, 0);
      drive(1'b1, 32'h7100, 32'h0130_0000 + 32'(9 * 64), 1'b1, 32'h0130_0000);
      idle(2);
      acc(32'h7100, 32'h0130_0800, 0);
      idle(3);
      e = '{};
      expect_list("R10", e);

      // R3 R5 R7 R8 R9: random mix against the model
      phase = "R3 R5 R7 R8 R9 random mix";
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom_range(0, 99);
         bit [31:0] b  = 32'h0200_0000 + 32'($urandom_range(0, 5)) * 32'h800;
         bit [31:0] pc = 32'h8000 + 32'($urandom_range(0, 3)) * 4;
         bit [31:0] a  = b + 32'($urandom_range(0, 31)) * 64 + 32'($urandom_range(0, 63));
         bit [31:0] eb = 32'h0200_0000 + 32'($urandom_range(0, 5)) * 32'h800 + 32'($urandom_range(0, 2047));
         pf_ready = ($urandom_range(0, 9) < 7);
         if (r < 4)       drive(1'b1, pc, a, 1'b1, eb);
         else if (r < 12) drive(1'b0, '0, '0, 1'b1, eb);
         else if (r < 75) drive(1'b1, pc, a, 1'b0, '0);
         else             drive(1'b0, '0, '0, 1'b0, '0);
      end
      pf_ready = 1'b1;
      idle(40);
      chk(pf_valid == 1'b0, "R8", "stream drained", 32'(pf_valid), 32'd0);
      summary();
      $finish;
   end

endmodule